// File: doc/BRIEF.md
# Clock Rate Selector with Deferred Update and Rate Clamping

This block turns one master clock into three clock-enable strobes: one for the processor and all bus masters, one for the on-chip peripherals, and one for the external bus interface. Each strobe rate is chosen by a 3-bit code that selects a divide ratio of a power of two. Software writes all three codes together as a single configuration word through a simple write port.

A write does not change the strobes at once. The word is held as a pending setting. It is applied only when the bus controller signals that the current bus cycle has ended. All three domains switch on the same master clock edge. Their dividers then restart together, so every slower strobe lines up with a faster one.

The peripheral and external bus domains may never run faster than the processor domain. If either one asks for a smaller divide ratio than the processor code gives, it runs at the processor ratio instead.

Top module: `clk_rate_ctl`

## Requirements
- R1: `wrData` holds three codes: bits [2:0] are the processor code, bits [5:3] the peripheral code and bits [8:6] the external bus code. A cycle with `wrEn` high captures all three as the pending setting.
- R2: A pending setting has no effect on any strobe until a cycle in which `busCycleEnd` is high. Until that cycle, the strobes keep the ratios and phase of the setting applied before.
- R3: Code N in 0..5 selects divide by 2^N. Count k = 0 as the first cycle after the apply edge. A strobe is high for exactly one master cycle, in each cycle where (k+1) is a multiple of its ratio. At ratio 1 it is high in every cycle.
- R4: The peripheral and external bus strobes run at the larger of their own requested ratio and the processor ratio.
- R5: Codes 6 and 7 behave as divide by 32.
- R6: All three domains take the new setting on the same edge, and their phases restart from k = 0. Whenever a slower strobe is high, every faster strobe is also high.
- R7: A `busCycleEnd` pulse with no setting pending changes neither the ratios nor the phase.
- R8: When `wrEn` and `busCycleEnd` are high in the same cycle, the earlier pending setting (if any) is applied. The newly written word stays pending for the next `busCycleEnd`.
- R9: After reset all three domains divide by 1, so every strobe is high in every cycle, and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the configuration word |
| wrData | input | 9 | Three 3-bit rate codes (processor, peripheral, external bus) |
| busCycleEnd | input | 1 | High in the cycle where the current bus cycle ends |
| cpuTick | output | 1 | Enable strobe for the processor and bus masters |
| perTick | output | 1 | Enable strobe for peripheral modules |
| extTick | output | 1 | Enable strobe for the external bus |

## Verification
The assertions assume that `wrEn`, `wrData` and `busCycleEnd` are known after reset. They also assume that `busCycleEnd` may arrive in any cycle, whether or not a setting is pending. The stimulus drives every input from the falling clock edge and never leaves one undefined. It pulses `busCycleEnd` both with and without pending data, and also in the same cycle as a write. It sweeps every pair of processor and peripheral codes, including the two codes that fall back to divide by 32.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int DOMAINS   = 3;
  localparam int SEL_W     = 3;
  localparam int MAX_SHIFT = 5;
  localparam int SHIFT_W   = $clog2(MAX_SHIFT + 1);
  localparam int CNT_W     = MAX_SHIFT;
  localparam int CFG_W     = DOMAINS * SEL_W;
  localparam int DOM_CPU   = 0;

  typedef logic [SHIFT_W-1:0] shift_t;

  // control-to-datapath strobe bundle
  typedef struct packed {
    logic                      apply;
    logic [DOMAINS-1:0][SHIFT_W-1:0] shift;
  } ctlStrobe_t;

  // rate code to log2 of divide ratio; out-of-range codes saturate
  function automatic shift_t decodeSel(input logic [SEL_W-1:0] code);
    if (code > SEL_W'(MAX_SHIFT)) return shift_t'(MAX_SHIFT);
    return shift_t'(code);
  endfunction
endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [CFG_W-1:0] wrData,
  input  logic             busCycleEnd,
  output ctlStrobe_t       strobes
);
  logic [CFG_W-1:0]   pendCfg;
  logic               pendValid;
  logic               applyNow;
  shift_t [DOMAINS-1:0] reqShift;
  shift_t [DOMAINS-1:0] nextShift;
  shift_t [DOMAINS-1:0] activeShift;

  assign applyNow = busCycleEnd & pendValid;

  genvar d;
  generate
    for (d = 0; d < DOMAINS; d++) begin : g_dom
      assign reqShift[d] = decodeSel(pendCfg[d*SEL_W +: SEL_W]);
      if (d == DOM_CPU) begin : g_lead
        assign nextShift[d] = reqShift[d];
      end else begin : g_clamp
        // never faster than the lead domain
        assign nextShift[d] = (reqShift[d] > reqShift[DOM_CPU]) ? reqShift[d] : reqShift[DOM_CPU];
      end

      // R5
      shift_range_chk: assert property (@(posedge clk) disable iff (!rstN)
        activeShift[d] <= shift_t'(MAX_SHIFT));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendCfg     <= '0;
      pendValid   <= 1'b0;
      activeShift <= '0;
    end else begin
      if (applyNow) activeShift <= nextShift;
      if (wrEn) begin
        pendCfg   <= wrData;
        pendValid <= 1'b1;
      end else if (applyNow) begin
        pendValid <= 1'b0;
      end
    end
  end

  assign strobes.apply = applyNow;
  assign strobes.shift = activeShift;

  // R2
  hold_until_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busCycleEnd |=> $stable(activeShift));

  // R8
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendValid && busCycleEnd && wrEn) |=> pendValid);

  // R7
  idle_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busCycleEnd && !pendValid) |=> $stable(activeShift));
endmodule

// File: rtl/clkdiv_dp.sv
module clkdiv_dp
  import clkdiv_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strobes,
  output logic [DOMAINS-1:0] ticks
);
  logic [CNT_W-1:0] phaseCnt;

  // one shared phase counter keeps every domain aligned
  always_ff @(posedge clk) begin
    if (!rstN)              phaseCnt <= '0;
    else if (strobes.apply) phaseCnt <= '0;
    else                    phaseCnt <= phaseCnt + 1'b1;
  end

  genvar d;
  generate
    for (d = 0; d < DOMAINS; d++) begin : g_tick
      logic [CNT_W-1:0] lowMask;
      assign lowMask  = ~({CNT_W{1'b1}} << strobes.shift[d]);
      assign ticks[d] = &(phaseCnt | ~lowMask);

      // R3
      single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
        (ticks[d] && !strobes.apply && strobes.shift[d] != '0) |=> !ticks[d]);

      if (d != DOM_CPU) begin : g_sub
        // R4
        not_faster_chk: assert property (@(posedge clk) disable iff (!rstN)
          ticks[d] |-> ticks[DOM_CPU]);
      end
    end
  endgenerate

  // R6
  phase_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.apply |=> (phaseCnt == '0));
endmodule

// File: rtl/clk_rate_ctl.sv
module clk_rate_ctl
  import clkdiv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [8:0] wrData,
  input  logic       busCycleEnd,
  output logic       cpuTick,
  output logic       perTick,
  output logic       extTick
);
  ctlStrobe_t         strobes;
  logic [DOMAINS-1:0] ticks;

  clkdiv_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrData     (wrData),
    .busCycleEnd(busCycleEnd),
    .strobes    (strobes)
  );

  clkdiv_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .ticks  (ticks)
  );

  assign cpuTick = ticks[0];
  assign perTick = ticks[1];
  assign extTick = ticks[2];
endmodule

// File: tb/clk_rate_ctl_test.sv
`timescale 1ns/1ps
module clk_rate_ctl_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [8:0] wrData = '0;
  logic       busCycleEnd = 1'b0;
  logic       cpuTick, perTick, extTick;

  clk_rate_ctl uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .busCycleEnd(busCycleEnd), .cpuTick(cpuTick), .perTick(perTick), .extTick(extTick)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int actShift[3];
  int pendCode[3];
  bit pendV = 0;
  int sinceApply = 0;
  bit prevWr = 0, prevBce = 0;
  logic [8:0] prevData = '0;
  string focus = "R9";

  function automatic int dec(input int c);
    return (c > 5) ? 5 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic checkBit(input string tag, input int dom, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s/%s dom%0d cycle %0d: tick=%b expected %b", tag, focus, dom, sinceApply, act, exp);
    end
  endtask

  // emulate one edge in the model, then compare, then drive next inputs
  task automatic tickCycle(input bit wr, input logic [8:0] d, input bit bce);
    logic [2:0] got;
    @(negedge clk);
    if (prevBce && pendV) begin
      actShift[0] = dec(pendCode[0]);
      actShift[1] = imax(dec(pendCode[1]), actShift[0]);
      actShift[2] = imax(dec(pendCode[2]), actShift[0]);
      sinceApply = 0;
      pendV = 0;
    end else begin
      sinceApply++;
    end
    if (prevWr) begin
      pendCode[0] = int'(prevData[2:0]);
      pendCode[1] = int'(prevData[5:3]);
      pendCode[2] = int'(prevData[8:6]);
      pendV = 1;
    end
    got = {extTick, perTick, cpuTick};
    for (int k = 0; k < 3; k++) begin
      int msk;
      string tag;
      msk = (1 << actShift[k]) - 1;
      if (pendV) tag = "R2";
      else if (k == 0) tag = "R3";
      else if (pendCode[k] > 5 || pendCode[0] > 5) tag = "R5";
      else tag = "R4";
      checkBit(tag, k, got[k], ((sinceApply & msk) == msk));
    end
    wrEn = wr; wrData = d; busCycleEnd = bce;
    prevWr = wr; prevData = d; prevBce = bce;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < 3; k++) begin actShift[k] = 0; pendCode[k] = 0; end
    // R9: held in reset, all strobes at divide by 1
    repeat (3) begin
      @(negedge clk);
      checkBit("R9", 0, cpuTick, 1'b1);
      checkBit("R9", 1, perTick, 1'b1);
      checkBit("R9", 2, extTick, 1'b1);
    end
    rstN = 1'b1;
    sinceApply = 0;
    // R9: nothing pending, end-of-cycle pulses change nothing
    for (int n = 0; n < 8; n++) tickCycle(0, '0, n[0]);

    // R1 sweep over processor and peripheral codes, external code varied
    for (int c = 0; c < 8; c++) begin
      for (int p = 0; p < 8; p++) begin
        int e;
        logic [8:0] w;
        e = (c * 3 + p * 5 + 1) % 8;
        w = {3'(e), 3'(p), 3'(c)};
        focus = "R1";
        tickCycle(1, w, 0);
        focus = "R2";
        for (int n = 0; n < 20; n++) tickCycle(0, '0, 0);
        tickCycle(0, '0, 1);
        // R6 first cycles after apply, R7 idle pulses later on
        focus = "R6";
        for (int n = 0; n < 40; n++) begin
          if (n == 8) focus = "R7";
          tickCycle(0, '0, (n % 13) == 5);
        end
      end
    end

    // R8: write coinciding with end-of-cycle
    focus = "R8";
    tickCycle(1, {3'd1, 3'd2, 3'd0}, 0);
    tickCycle(1, {3'd7, 3'd4, 3'd2}, 1);
    for (int n = 0; n < 12; n++) tickCycle(0, '0, 0);
    tickCycle(0, '0, 1);
    for (int n = 0; n < 70; n++) tickCycle(0, '0, 0);
    // R8: write plus end-of-cycle with nothing pending stays pending
    tickCycle(1, {3'd0, 3'd0, 3'd0}, 1);
    for (int n = 0; n < 10; n++) tickCycle(0, '0, 0);
    tickCycle(0, '0, 1);
    for (int n = 0; n < 10; n++) tickCycle(0, '0, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule